// File: doc/BRIEF.md
# Right-to-left modular exponentiation controller

This block computes `base^expo mod modulus` with Montgomery arithmetic, walking the exponent from its least significant bit upward. Two iterative Montgomery multipliers of their own sit inside the block. In each exponent step, one multiplier squares the running power and the other, only when the current exponent bit is set, folds that power into the accumulator. Both operations of a step start on the same clock edge, so a step costs one multiplication time.

An opening phase brings the operands into the Montgomery domain. It multiplies the supplied value `R^2 mod M` by 1 to form the accumulator, and by the base to form the power, with R = 2^W. A closing phase multiplies the accumulator by 1 to leave the domain, and that product is the result.

The caller supplies:
- the odd modulus;
- `R^2 mod M`;
- the digit constant `-M^-1 mod 2^D`.

The caller then pulses `start` and waits for `ready`. The multipliers retire D bits of an operand per cycle. The scan always covers all EW exponent bits, so the run time does not depend on the data.

Top module: `rl_modexp`

## Requirements
- R1: While reset is applied and after it is released, `ready` is 0 and `result` is 0 until the first operation completes.
- R2: With modulus M odd and 1 < M < 2^W, base B < M, `r2_mod` = 2^(2W) mod M and `mont_const` = (-M^-1) mod 2^D, the completed `result` equals B^E mod M. A result shown with `ready` high is always below the latched modulus.
- R3: An exponent of 0 yields a result of 1.
- R4: An exponent of 1 yields the base itself.
- R5: An exponent with all EW bits set yields B^(2^EW - 1) mod M.
- R6: While an operation runs, `ready` stays low and a `start` pulse is ignored. The running operation finishes with its original operands and with unchanged timing.
- R7: `ready` drops after the clock edge that accepts `start`, and rises on the edge that writes `result`. After that, `result` and `ready` hold, whatever the other inputs do, until the next `start`.
- R8: `ready` rises exactly (EW+2)*(W/D+3) clock edges after the edge that accepts `start`, for every exponent value.
- R9: In each exponent step, the squaring and the conditional multiply are issued on the same edge, to two separate multipliers. The multiply is issued only for a set bit, and when issued it completes in the same cycle as the squaring. A set bit therefore adds no time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| base | input | W | Base B, below the modulus |
| expo | input | EW | Exponent E |
| modulus | input | W | Odd modulus M |
| r2_mod | input | W | 2^(2W) mod M |
| mont_const | input | D | (-M^-1) mod 2^D |
| ready | output | 1 | High while `result` holds a completed value |
| result | output | W | B^E mod M |

## Verification
On every cycle, the assertions check four things:
- `ready` stays low for as long as the controller is away from idle;
- a completed result holds steady until a new start and lies below the latched modulus;
- no multiplier is restarted while its previous product is still pending;
- a multiply issued within an exponent step finishes in the same cycle as its squaring.

Only the bench's scenarios can show that the arithmetic is right. The bench sweeps every odd modulus of a small configuration at exponents of 0, 1 and all-ones. It also sweeps every exponent value for one modulus, and it measures that the latency is the same whatever the exponent bits are.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_W,
    ST_STEP,
    ST_STEP_W,
    ST_POST,
    ST_POST_W
  } ctl_state_e;

  // lane 0 carries accumulator updates, lane 1 carries squarings
  localparam int LANE_MUL = 0;
  localparam int LANE_SQR = 1;
  localparam int N_LANES  = 2;

endpackage

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int W = 32,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic [D-1:0] mc,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int ITER = W / D;
  localparam int CW   = $clog2(ITER + 1);
  localparam int ZW   = W + D + 1;

  // one radix-2^D digit of the interleaved product and reduction
  function automatic logic [W:0] mont_digit(input logic [W:0]   z,
                                            input logic [D-1:0] xd,
                                            input logic [W-1:0] y,
                                            input logic [W-1:0] mm,
                                            input logic [D-1:0] c);
    logic [ZW-1:0] t;
    logic [D-1:0]  q;
    logic [ZW-1:0] u;
    t = ZW'(z) + ZW'(xd) * ZW'(y);
    q = t[D-1:0] * c;
    u = t + ZW'(q) * ZW'(mm);
    return u[ZW-1:D];
  endfunction

  function automatic logic [W-1:0] final_sub(input logic [W:0] z, input logic [W-1:0] mm);
    logic [W:0] d;
    d = z - {1'b0, mm};
    return (z >= {1'b0, mm}) ? d[W-1:0] : z[W-1:0];
  endfunction

  logic [W-1:0]  x_sh, y_r, m_r;
  logic [D-1:0]  c_r;
  logic [W:0]    z_r;
  logic [CW-1:0] cnt;
  logic          run, fix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_sh <= '0; y_r <= '0; m_r <= '0; c_r <= '0; z_r <= '0;
      cnt <= '0; run <= 1'b0; fix <= 1'b0; done <= 1'b0; res <= '0;
    end else begin
      done <= 1'b0;
      if (go && !run && !fix) begin
        x_sh <= a;
        y_r  <= b;
        m_r  <= m;
        c_r  <= mc;
        z_r  <= '0;
        cnt  <= '0;
        run  <= 1'b1;
      end else if (run) begin
        z_r  <= mont_digit(z_r, x_sh[D-1:0], y_r, m_r, c_r);
        x_sh <= x_sh >> D;
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(ITER - 1)) begin
          run <= 1'b0;
          fix <= 1'b1;
        end
      end else if (fix) begin
        res  <= final_sub(z_r, m_r);
        done <= 1'b1;
        fix  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/exp_scan.sv
module exp_scan #(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [EW-1:0] exp_in,
  output logic          cur_bit,
  output logic          last_bit
);
  localparam int IW = $clog2(EW + 1);

  logic [EW-1:0] e_sh;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_sh <= '0;
      idx  <= '0;
    end else if (load) begin
      e_sh <= exp_in;
      idx  <= '0;
    end else if (adv) begin
      e_sh <= e_sh >> 1;
      idx  <= idx + 1'b1;
    end
  end

  assign cur_bit  = e_sh[0];
  assign last_bit = (idx == IW'(EW - 1));

endmodule

// File: rtl/rl_modexp.sv
module rl_modexp
  import modexp_pkg::*;
#(
  parameter int W  = 32,
  parameter int D  = 4,
  parameter int EW = W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  base,
  input  logic [EW-1:0] expo,
  input  logic [W-1:0]  modulus,
  input  logic [W-1:0]  r2_mod,
  input  logic [D-1:0]  mont_const,
  output logic          ready,
  output logic [W-1:0]  result
);
  ctl_state_e         st;
  logic [W-1:0]       m_r, b_r, r2_r, s_r, z_r;
  logic [D-1:0]       c_r;
  logic [N_LANES-1:0] pend, pend_n, lane_go, lane_done;
  logic [W-1:0]       op_a [N_LANES];
  logic [W-1:0]       op_b [N_LANES];
  logic [W-1:0]       lane_res [N_LANES];
  logic               cur_bit, last_bit;

  // named events
  logic accept, phase_done, step_adv;
  assign accept     = (st == ST_IDLE) && start;
  assign pend_n     = pend & ~lane_done;
  assign phase_done = (pend_n == '0);
  assign step_adv   = (st == ST_STEP_W) && phase_done;

  exp_scan #(.EW(EW)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(step_adv),
    .exp_in(expo), .cur_bit(cur_bit), .last_bit(last_bit)
  );

  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      op_a[i] = '0;
      op_b[i] = '0;
    end
    lane_go = '0;
    case (st)
      ST_PRE: begin
        op_a[LANE_MUL] = r2_r; op_b[LANE_MUL] = W'(1);
        op_a[LANE_SQR] = r2_r; op_b[LANE_SQR] = b_r;
        lane_go = '1;
      end
      ST_STEP: begin
        op_a[LANE_MUL] = s_r; op_b[LANE_MUL] = z_r;
        op_a[LANE_SQR] = z_r; op_b[LANE_SQR] = z_r;
        lane_go[LANE_MUL] = cur_bit;
        lane_go[LANE_SQR] = 1'b1;
      end
      ST_POST: begin
        op_a[LANE_MUL] = s_r; op_b[LANE_MUL] = W'(1);
        lane_go[LANE_MUL] = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    mont_mul #(.W(W), .D(D)) u_mm (
      .clk(clk), .rst_n(rst_n), .go(lane_go[g]),
      .a(op_a[g]), .b(op_b[g]), .m(m_r), .mc(c_r),
      .done(lane_done[g]), .res(lane_res[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      m_r <= '0; b_r <= '0; r2_r <= '0; c_r <= '0;
      s_r <= '0; z_r <= '0; pend <= '0;
      ready <= 1'b0; result <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          m_r <= modulus; b_r <= base; r2_r <= r2_mod; c_r <= mont_const;
          ready <= 1'b0;
          st <= ST_PRE;
        end
        ST_PRE:  begin pend <= lane_go; st <= ST_PRE_W;  end
        ST_STEP: begin pend <= lane_go; st <= ST_STEP_W; end
        ST_POST: begin pend <= lane_go; st <= ST_POST_W; end
        ST_PRE_W, ST_STEP_W: begin
          pend <= pend_n;
          if (lane_done[LANE_MUL]) s_r <= lane_res[LANE_MUL];
          if (lane_done[LANE_SQR]) z_r <= lane_res[LANE_SQR];
          if (phase_done) begin
            if (st == ST_PRE_W)  st <= ST_STEP;
            else if (last_bit)   st <= ST_POST;
            else                 st <= ST_STEP;
          end
        end
        ST_POST_W: begin
          pend <= pend_n;
          if (phase_done) begin
            result <= lane_res[LANE_MUL];
            ready  <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rl_modexp_chk.sv
module rl_modexp_chk
  import modexp_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic [W-1:0] result,
  input logic [W-1:0] m_r,
  input ctl_state_e   st,
  input logic [1:0]   lane_go,
  input logic [1:0]   lane_done,
  input logic [1:0]   pend
);

  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(result)));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !ready);

  assert_result_reduced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (result < m_r));

  assert_lanes_finish_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_STEP_W) && lane_done[LANE_MUL]) |-> lane_done[LANE_SQR]);

  assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_go & pend) == 2'b00);

endmodule

bind rl_modexp rl_modexp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .result(result),
  .m_r(m_r), .st(st), .lane_go(lane_go), .lane_done(lane_done), .pend(pend)
);

// File: tb/rl_modexp_test.sv
module rl_modexp_test;
  localparam int W  = 8;
  localparam int D  = 2;
  localparam int EW = 8;
  localparam int LAT = (EW + 2) * (W / D + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  base = '0, modulus = '0, r2_mod = '0;
  logic [EW-1:0] expo = '0;
  logic [D-1:0]  mont_const = '0;
  logic          ready;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rl_modexp #(.W(W), .D(D), .EW(EW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .r2_mod(r2_mod), .mont_const(mont_const),
    .ready(ready), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_pow(input longint b, input int e, input longint m);
    longint r = 1;
    for (int i = EW - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if ((e >> i) & 1) r = (r * b) % m;
    end
    return r % m;
  endfunction

  function automatic int r2_of(input int m);
    return int'((64'd1 << (2 * W)) % m);
  endfunction

  function automatic int mc_of(input int m);
    for (int c = 0; c < (1 << D); c++)
      if (((m * c) + 1) % (1 << D) == 0) return c;
    return 0;
  endfunction

  task automatic run_op(input int b, input int e, input int m, input bit inject,
                        output int res, output int lat);
    bit fin = 0;
    @(negedge clk);
    base = W'(b); expo = EW'(e); modulus = W'(m);
    r2_mod = W'(r2_of(m)); mont_const = D'(mc_of(m)); start = 1'b1;
    lat = 0;
    while (!fin && lat < 2000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (lat == 1) chk(ready == 1'b0, "R7 ready drop after start", ready, 0);
      if (inject && lat == 20) begin
        start = 1'b1; base = 8'd1; expo = 8'd3; modulus = 8'd9; r2_mod = 8'd1;
      end
      if (inject && lat > 1 && !ready) begin end
      if (ready) fin = 1;
    end
    if (!fin) chk(1'b0, "R8 operation timeout", lat, LAT);
    res = int'(result);
    lat = lat - 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int res, lat, lat0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready in reset", ready, 0);
    chk(result == '0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", ready, 0);
    chk(result == '0, "R1 result after reset", result, 0);

    // every odd modulus: exponent 0, 1 and all-ones
    for (int m = 3; m < 256; m += 2) begin
      run_op(m - 1, 0, m, 1'b0, res, lat0);
      chk(res == 1, "R3 zero exponent", res, 1);
      chk(lat0 == LAT, "R8 latency zero exponent", lat0, LAT);
      run_op((m * 7 + 3) % m, 1, m, 1'b0, res, lat);
      chk(res == (m * 7 + 3) % m, "R4 unit exponent", res, (m * 7 + 3) % m);
      run_op(m / 2, 255, m, 1'b0, res, lat);
      chk(res == ref_pow(m / 2, 255, m), "R5 all-ones exponent", res, ref_pow(m / 2, 255, m));
      chk(lat == lat0, "R9 set bits add no time", lat, lat0);
    end

    // every exponent for one modulus
    for (int e = 0; e < 256; e++) begin
      run_op(2 + (e % 200), e, 251, 1'b0, res, lat);
      chk(res == ref_pow(2 + (e % 200), e, 251), "R2 exponent sweep", res,
          ref_pow(2 + (e % 200), e, 251));
      chk(lat == LAT, "R8 latency exponent sweep", lat, LAT);
    end

    // start during a run is ignored
    run_op(77, 8'hA5, 233, 1'b1, res, lat);
    chk(res == ref_pow(77, 8'hA5, 233), "R6 result with mid-run start", res, ref_pow(77, 8'hA5, 233));
    chk(lat == LAT, "R6 latency with mid-run start", lat, LAT);

    // result holds after completion while inputs change
    base = 8'd5; expo = 8'd9; modulus = 8'd11; r2_mod = 8'd3; mont_const = 2'd1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(ready == 1'b1 && int'(result) == res, "R7 hold after completion", result, res);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule